// File: doc/BRIEF.md
# Quick-Arbitration Bus Release Sequencer

This block runs on the target side of a parallel SCSI bus. When a DT DATA phase ends and quick arbitration is enabled, it gives up the bus without a full BUS FREE phase. It sends the one-byte quick-arbitration request message in a MESSAGE IN phase. It then lets go of its lines in a fixed order, with each step timed. Finally it watches SEL and the ID bits on the data lines to find out whether another device has won the bus.

There are three ways the sequence can end:
- **Handoff:** a selecting device asserts SEL.
- **Bus free:** no device claims the bus before the arbitration windows close.
- **Unexpected bus free:** the initiator raised attention during the message handshake, so the block takes the message bytes in a MESSAGE OUT phase and then drops the bus.

Every released line is shown as a deasserted output enable, with its value held at 0. The ACK, ATN and SEL inputs each pass through a two-flop synchronizer. The deskew, release and arbitration delays are parameters counted in clock cycles.

Top module: `qas_release_seq`

## Requirements
- R1: After reset, every output enable is low, `done_o` is low and `outcome_o` is 0.
- R2: In the cycle after `start_i` is seen with `qas_en_i` high while idle, the block drives the MESSAGE IN phase. BSY, MSG, C/D and I/O are all driven to 1, REQ is driven to 1, and the data lines are driven to 0x55.
- R3: A `start_i` seen while `qas_en_i` is low has no effect. All output enables stay low.
- R4: ACK, ATN and SEL take effect two cycles after they change. While REQ is high in the handshake, ACK high drives REQ to 0. When ACK then goes low with no attention, three things happen:
  - the data lines are released;
  - MSG, C/D and I/O are driven to 0, and REQ is held driven at 0, for 2*DESKEW_CYC cycles;
  - REQ is then released, while BSY, MSG, C/D and I/O stay driven.
- R5: If SEL is seen during an arbitration window, every line is released in the next cycle. A handoff outcome follows REL_CYC cycles later.
- R6: If no SEL arrives, the first arbitration window lasts ARB_CYC cycles. If the ID bits are all zero at its end, a bus free outcome follows.
- R7: If any ID bit is set at the end of the first window, a second window of ARB_CYC cycles follows. If it ends without SEL, a bus free outcome follows.
- R8: If ATN is seen at any point in the MESSAGE IN handshake, the block enters MESSAGE OUT. In that phase MSG=1, C/D=1 and I/O=0, and the data lines are released. It repeats REQ/ACK byte handshakes while ATN stays high. When a handshake ends with ATN low, it reports an unexpected bus free with all lines released.
- R9: `done_o` is a one-cycle pulse. While `done_o` is high, `outcome_o` gives the result: 1 is handoff, 2 is bus free, 3 is unexpected bus free. At all other times `outcome_o` is 0. The block is idle again in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to begin the release sequence |
| qas_en_i | input | 1 | Quick arbitration enabled |
| ack_i | input | 1 | ACK from the bus, asynchronous |
| atn_i | input | 1 | ATN from the bus, asynchronous |
| sel_i | input | 1 | SEL from the bus, asynchronous |
| id_i | input | 8 | Data lines as seen on the bus (arbitration IDs) |
| bsy_o | output | 1 | BSY value |
| bsy_oe | output | 1 | BSY drive enable |
| msg_o | output | 1 | MSG value |
| msg_oe | output | 1 | MSG drive enable |
| cd_o | output | 1 | C/D value |
| cd_oe | output | 1 | C/D drive enable |
| io_o | output | 1 | I/O value |
| io_oe | output | 1 | I/O drive enable |
| req_o | output | 1 | REQ value |
| req_oe | output | 1 | REQ drive enable |
| dat_o | output | 8 | Data byte value |
| dat_oe | output | 1 | Data byte drive enable |
| done_o | output | 1 | One-cycle completion pulse |
| outcome_o | output | 2 | Result code, valid with done_o |

## Verification
The assertions check the following on every cycle:
- a start is accepted or ignored according to the enable;
- REQ responds to the synchronized ACK;
- a synchronized SEL during arbitration releases every line at once;
- the closing MESSAGE OUT handshake with ATN low ends in an unexpected bus free;
- the completion pulse is one cycle long and its outcome code is valid.

Only the bench scenarios can show the full timing of each path. That covers the length of the REQ hold after the phase lines are negated, whether one or two arbitration windows elapse depending on the ID bits, and multi-byte MESSAGE OUT handshakes. The cycle-accurate reference model compares every output on every clock.

// File: rtl/qas_release_seq.sv
module qas_release_seq #(
  parameter int DESKEW_CYC = 2,
  parameter int REL_CYC    = 3,
  parameter int ARB_CYC    = 6,
  parameter logic [7:0] QAS_MSG = 8'h55
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       qas_en_i,
  input  logic       ack_i,
  input  logic       atn_i,
  input  logic       sel_i,
  input  logic [7:0] id_i,
  output logic       bsy_o,
  output logic       bsy_oe,
  output logic       msg_o,
  output logic       msg_oe,
  output logic       cd_o,
  output logic       cd_oe,
  output logic       io_o,
  output logic       io_oe,
  output logic       req_o,
  output logic       req_oe,
  output logic [7:0] dat_o,
  output logic       dat_oe,
  output logic       done_o,
  output logic [1:0] outcome_o
);
  localparam int NEG_LEN = 2 * DESKEW_CYC;
  localparam int MAX_A   = (NEG_LEN > REL_CYC) ? NEG_LEN : REL_CYC;
  localparam int MAX_LEN = (MAX_A > ARB_CYC) ? MAX_A : ARB_CYC;
  localparam int CW      = $clog2(MAX_LEN + 1);
  localparam logic [CW-1:0] NEG_LD = CW'(NEG_LEN - 1);
  localparam logic [CW-1:0] ARB_LD = CW'(ARB_CYC - 1);
  localparam logic [CW-1:0] REL_LD = CW'(REL_CYC - 1);

  typedef enum logic [3:0] {
    S_IDLE, S_MI_REQ, S_MI_ACK, S_NEG, S_ARB1, S_ARB2,
    S_REL, S_MO_REQ, S_MO_ACK, S_DONE
  } st_t;

  st_t state, state_n;
  logic [CW-1:0] cnt;
  logic [1:0] ack_q, atn_q, sel_q;
  logic ack_s, atn_s, sel_s;
  logic atn_seen;
  logic [1:0] res_q, res_n;
  logic in_idle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q <= '0;
      atn_q <= '0;
      sel_q <= '0;
    end else begin
      ack_q <= {ack_q[0], ack_i};
      atn_q <= {atn_q[0], atn_i};
      sel_q <= {sel_q[0], sel_i};
    end
  end

  assign ack_s = ack_q[1];
  assign atn_s = atn_q[1];
  assign sel_s = sel_q[1];
  assign in_idle = (state == S_IDLE);

  always_comb begin
    state_n = state;
    res_n   = res_q;
    unique case (state)
      S_IDLE:   if (start_i && qas_en_i) state_n = S_MI_REQ;
      S_MI_REQ: if (ack_s) state_n = S_MI_ACK;
      S_MI_ACK: if (!ack_s) state_n = (atn_seen || atn_s) ? S_MO_REQ : S_NEG;
      S_NEG:    if (cnt == '0) state_n = S_ARB1;
      S_ARB1: begin
        if (sel_s) state_n = S_REL;
        else if (cnt == '0) begin
          if (id_i != '0) state_n = S_ARB2;
          else begin
            state_n = S_DONE;
            res_n   = 2'd2;
          end
        end
      end
      S_ARB2: begin
        if (sel_s) state_n = S_REL;
        else if (cnt == '0) begin
          state_n = S_DONE;
          res_n   = 2'd2;
        end
      end
      S_REL: if (cnt == '0) begin
        state_n = S_DONE;
        res_n   = 2'd1;
      end
      S_MO_REQ: if (ack_s) state_n = S_MO_ACK;
      S_MO_ACK: if (!ack_s) begin
        if (atn_s) state_n = S_MO_REQ;
        else begin
          state_n = S_DONE;
          res_n   = 2'd3;
        end
      end
      S_DONE:   state_n = S_IDLE;
      default:  state_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cnt      <= '0;
      res_q    <= 2'd0;
      atn_seen <= 1'b0;
    end else begin
      state <= state_n;
      res_q <= res_n;
      if (state_n != state) begin
        unique case (state_n)
          S_NEG:          cnt <= NEG_LD;
          S_ARB1, S_ARB2: cnt <= ARB_LD;
          S_REL:          cnt <= REL_LD;
          default:        cnt <= '0;
        endcase
      end else if (cnt != '0) begin
        cnt <= cnt - 1'b1;
      end
      if (state == S_IDLE) atn_seen <= 1'b0;
      else if ((state == S_MI_REQ || state == S_MI_ACK) && atn_s) atn_seen <= 1'b1;
    end
  end

  assign bsy_oe = state inside {S_MI_REQ, S_MI_ACK, S_NEG, S_ARB1, S_ARB2, S_MO_REQ, S_MO_ACK};
  assign bsy_o  = bsy_oe;
  assign msg_oe = bsy_oe;
  assign cd_oe  = bsy_oe;
  assign io_oe  = bsy_oe;
  assign msg_o  = state inside {S_MI_REQ, S_MI_ACK, S_MO_REQ, S_MO_ACK};
  assign cd_o   = msg_o;
  assign io_o   = state inside {S_MI_REQ, S_MI_ACK};
  assign req_oe = state inside {S_MI_REQ, S_MI_ACK, S_NEG, S_MO_REQ, S_MO_ACK};
  assign req_o  = state inside {S_MI_REQ, S_MO_REQ};
  assign dat_oe = io_o;
  assign dat_o  = dat_oe ? QAS_MSG : 8'h00;
  assign done_o = (state == S_DONE);
  assign outcome_o = done_o ? res_q : 2'd0;
endmodule

// File: rtl/qas_release_seq_chk.sv
module qas_release_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_idle,
  input logic       start_i,
  input logic       qas_en_i,
  input logic       ack_s,
  input logic       atn_s,
  input logic       sel_s,
  input logic       bsy_oe,
  input logic       msg_o,
  input logic       io_o,
  input logic       req_oe,
  input logic       req_o,
  input logic       dat_oe,
  input logic [7:0] dat_o,
  input logic       done_o,
  input logic [1:0] outcome_o
);
  assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_idle && start_i && qas_en_i) |=> (dat_oe && dat_o == 8'h55 && req_o && bsy_oe));

  assert_ignore_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_idle && !qas_en_i) |=> !bsy_oe);

  assert_req_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_oe && req_o && dat_oe && ack_s) |=> (req_oe && !req_o));

  assert_sel_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bsy_oe && !req_oe && sel_s) |=> (!bsy_oe && !req_oe && !dat_oe));

  assert_msgout_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bsy_oe && msg_o && !io_o && req_oe && !req_o && !ack_s && !atn_s)
      |=> (done_o && outcome_o == 2'd3 && !bsy_oe));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!done_o && in_idle));

  assert_outcome_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (outcome_o != 2'd0));
endmodule

bind qas_release_seq qas_release_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_idle(in_idle), .start_i(start_i),
  .qas_en_i(qas_en_i), .ack_s(ack_s), .atn_s(atn_s), .sel_s(sel_s),
  .bsy_oe(bsy_oe), .msg_o(msg_o), .io_o(io_o), .req_oe(req_oe),
  .req_o(req_o), .dat_oe(dat_oe), .dat_o(dat_o), .done_o(done_o),
  .outcome_o(outcome_o)
);

// File: tb/tb_qas_release_seq.sv
`timescale 1ns/1ps
module tb_qas_release_seq;
  localparam int DSK = 2, REL = 3, ARB = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_i = 0, qas_en_i = 0, ack_i = 0, atn_i = 0, sel_i = 0;
  logic [7:0] id_i = 8'h00;
  logic bsy_o, bsy_oe, msg_o, msg_oe, cd_o, cd_oe, io_o, io_oe, req_o, req_oe;
  logic [7:0] dat_o;
  logic dat_oe, done_o;
  logic [1:0] outcome_o;

  int checks = 0, errors = 0, cycles = 0;

  always #10 clk = ~clk;

  qas_release_seq #(.DESKEW_CYC(DSK), .REL_CYC(REL), .ARB_CYC(ARB)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .qas_en_i(qas_en_i),
    .ack_i(ack_i), .atn_i(atn_i), .sel_i(sel_i), .id_i(id_i),
    .bsy_o(bsy_o), .bsy_oe(bsy_oe), .msg_o(msg_o), .msg_oe(msg_oe),
    .cd_o(cd_o), .cd_oe(cd_oe), .io_o(io_o), .io_oe(io_oe),
    .req_o(req_o), .req_oe(req_oe), .dat_o(dat_o), .dat_oe(dat_oe),
    .done_o(done_o), .outcome_o(outcome_o)
  );

  // Behavioural reference: phase number, time in phase, input delay lines.
  localparam int P_IDLE = 0, P_MI = 1, P_MIA = 2, P_NEG = 3, P_W1 = 4,
                 P_W2 = 5, P_REL = 6, P_MO = 7, P_MOA = 8, P_FIN = 9;
  int ph = P_IDLE, t = 0, res = 0;
  bit ackd[$], atnd[$], seld[$];
  bit atnf = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph = P_IDLE; t = 0; res = 0; atnf = 0;
      ackd = '{0, 0}; atnd = '{0, 0}; seld = '{0, 0};
    end else begin
      int nx;
      bit a, n, s;
      a = ackd[0]; n = atnd[0]; s = seld[0];
      nx = ph;
      case (ph)
        P_IDLE: if (start_i && qas_en_i) begin nx = P_MI; atnf = 0; end
        P_MI:   begin if (n) atnf = 1; if (a) nx = P_MIA; end
        P_MIA:  begin if (n) atnf = 1; if (!a) nx = atnf ? P_MO : P_NEG; end
        P_NEG:  if (t == 2*DSK-1) nx = P_W1;
        P_W1:   if (s) nx = P_REL;
                else if (t == ARB-1) begin
                  if (id_i != 0) nx = P_W2; else begin nx = P_FIN; res = 2; end
                end
        P_W2:   if (s) nx = P_REL; else if (t == ARB-1) begin nx = P_FIN; res = 2; end
        P_REL:  if (t == REL-1) begin nx = P_FIN; res = 1; end
        P_MO:   if (a) nx = P_MOA;
        P_MOA:  if (!a) begin if (n) nx = P_MO; else begin nx = P_FIN; res = 3; end end
        default: nx = P_IDLE;
      endcase
      t = (nx != ph) ? 0 : t + 1;
      ph = nx;
      void'(ackd.pop_front()); ackd.push_back(ack_i);
      void'(atnd.pop_front()); atnd.push_back(atn_i);
      void'(seld.pop_front()); seld.push_back(sel_i);
    end
  end

  function automatic string tag_of(int p);
    case (p)
      P_IDLE: return "R1";
      P_MI, P_MIA: return "R2";
      P_NEG: return "R4";
      P_W1, P_W2: return "R6";
      P_REL: return "R5";
      P_MO, P_MOA: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      bit own, ph_on, mi, mo;
      int exp_v, act_v;
      own   = ph inside {P_MI, P_MIA, P_NEG, P_W1, P_W2, P_MO, P_MOA};
      mi    = ph inside {P_MI, P_MIA};
      mo    = ph inside {P_MO, P_MOA};
      ph_on = mi || mo;
      exp_v = {own, own, own, ph_on, own, ph_on, own, mi,
               (mi || mo || ph == P_NEG), (ph == P_MI || ph == P_MO),
               mi, (mi ? 8'h55 : 8'h00), (ph == P_FIN), (ph == P_FIN ? res[1:0] : 2'd0)};
      act_v = {bsy_oe, bsy_o, msg_oe, msg_o, cd_oe, cd_o, io_oe, io_o,
               req_oe, req_o, dat_oe, dat_o, done_o, outcome_o};
      chk(tag_of(ph), "outputs vs model", act_v, exp_v);
    end
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic tick(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic kick();
    qas_en_i = 1; start_i = 1; @(negedge clk); start_i = 0;
  endtask

  task automatic handshake(bit drop_atn);
    while (!req_o) @(negedge clk);
    ack_i = 1;
    while (req_o) @(negedge clk);
    if (drop_atn) atn_i = 0;
    ack_i = 0;
  endtask

  task automatic finish_run(int exp_code, int exp_win, string tag);
    int win = 0;
    while (!done_o) begin
      if (bsy_oe && msg_oe && !req_oe) win++;
      @(negedge clk);
    end
    chk(tag, "outcome code", outcome_o, exp_code);
    if (exp_win >= 0) chk(tag, "arbitration cycles", win, exp_win);
    @(negedge clk);
    chk("R9", "done width", done_o, 0);
  endtask

  initial begin
    tick(3);
    chk("R1", "reset enables", {bsy_oe, msg_oe, req_oe, dat_oe, done_o}, 0);
    rst_n = 1;
    tick(2);
    chk("R1", "idle after reset", {bsy_oe, req_oe, outcome_o}, 0);

    // R3: start ignored with quick arbitration disabled
    qas_en_i = 0; start_i = 1; @(negedge clk); start_i = 0;
    tick(3);
    chk("R3", "no drive when disabled", {bsy_oe, req_oe, dat_oe}, 0);

    // R2, R4, R6: no SEL, no IDs -> bus free after one window
    id_i = 8'h00;
    kick();
    chk("R2", "message in byte", {dat_oe, dat_o, msg_o, cd_o, io_o, req_o}, {1'b1, 8'h55, 4'hF});
    handshake(0);
    begin
      int hold = 0;
      @(negedge clk);
      while (!(bsy_oe && !req_oe)) begin
        if (req_oe && !msg_o && bsy_oe) hold++;
        @(negedge clk);
      end
      chk("R4", "REQ hold after phase negate", hold, 2*DSK);
    end
    finish_run(2, ARB, "R6");

    // R7: IDs present, no SEL -> bus free after two windows
    id_i = 8'h09;
    kick(); handshake(0);
    finish_run(2, 2*ARB, "R7");

    // R5: SEL early in first window -> handoff
    id_i = 8'h00;
    kick(); handshake(0);
    while (!(bsy_oe && !req_oe)) @(negedge clk);
    @(negedge clk); sel_i = 1;
    finish_run(1, -1, "R5");
    sel_i = 0; tick(3);

    // R5, R7: SEL during second window
    id_i = 8'h40;
    kick(); handshake(0);
    while (!(bsy_oe && !req_oe)) @(negedge clk);
    tick(ARB + 1); sel_i = 1;
    finish_run(1, -1, "R5");
    sel_i = 0; id_i = 8'h00; tick(3);

    // R8: attention -> MESSAGE OUT, two bytes, unexpected bus free
    atn_i = 1;
    kick(); handshake(0);
    while (!req_o) @(negedge clk);
    chk("R8", "message out phase", {msg_o, cd_o, io_o, dat_oe}, 4'b1100);
    handshake(0);
    handshake(1);
    finish_run(3, 0, "R8");

    // R8: attention raised late, only during ACK of the handshake
    kick();
    while (!req_o) @(negedge clk);
    ack_i = 1;
    while (req_o) @(negedge clk);
    atn_i = 1; tick(3); ack_i = 0;
    handshake(1);
    finish_run(3, 0, "R8");

    tick(4);
    chk("R9", "idle at end", {bsy_oe, done_o, outcome_o}, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule